// File: doc/BRIEF.md
# Audio serial clock and frame generator

This block produces the bit-clock and word-select timing for a serial audio output link to an external D/A converter. It runs entirely on the oversampling clock. In master mode it divides the oversampling clock into a serial bit clock and divides that bit clock into a word-select waveform whose period is one serial frame. It drives both pins, and their output enables are asserted.

In slave mode the converter drives both pins. The block samples them through two-flop synchronizers, and its output enables stay low. In both modes a downstream parallel-to-serial shifter receives two one-cycle strobes: a bit enable for each bit period and a frame start for each frame. The shifter therefore does not need to know which side is the timing master.

The divider ratio and the frame length can be written at any time. Each new value is captured only at a frame boundary, so a frame in progress keeps its length. The interface has no data stream, so it has no valid/ready handshake. Every pin is a plain level or a one-cycle strobe.

Top module: `aud_frame_gen`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it is sampled, `bclk_oe`, `wsel_oe`, `bclk_out`, `wsel_out`, `bit_en` and `frame_start` are all 0.
- R2: In master mode with ratio field N (8 bits, 0 to 255), one bit period lasts N+1 oversampling cycles. `bit_en` pulses exactly once per period, in its first cycle.
- R3: In master mode `bclk_out` is high for floor((N+1)/2) cycles at the start of each bit period and low for the rest of it. With N = 0, `bit_en` is high in every cycle and `bclk_out` stays low.
- R4: In master mode with frame field W (8 bits), a frame spans W+1 bit periods. `frame_start` pulses in the first cycle of each frame, together with that cycle's `bit_en`.
- R5: In master mode `wsel_out` is low for the first (W+1) - floor((W+1)/2) bit periods of a frame and high for the remaining floor((W+1)/2). An odd frame length therefore gives the extra bit to the low phase, and the frame begins on the falling edge of word select.
- R6: With `master_en` = 1, the first frame starts in the cycle after the first clock edge that samples reset low. From that cycle on, both output enables are high.
- R7: A new ratio or frame value written in the middle of a frame does not change the current frame. It applies from the next frame onward.
- R8: With `master_en` = 0, both output enables and both pin outputs are 0 from the next cycle on. `bit_en` pulses for one cycle, two clock edges after a rising edge of `bclk_in` is set up. A falling edge of `bclk_in` produces no pulse.
- R9: With `master_en` = 0, `frame_start` pulses for one cycle, two clock edges after a falling edge of `wsel_in`. A rising edge of `wsel_in` produces no pulse.
- R10: When `master_en` returns from 0 to 1, the block starts a fresh frame in the cycle after the next clock edge, with the enables asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | 1 | 1: drive bit clock and word select; 0: receive them |
| bclk_ratio | input | DW | Bit-clock divide field N (period N+1) |
| frame_len | input | DW | Frame field W (W+1 bits per frame) |
| bclk_in | input | 1 | Bit-clock pin, received value |
| bclk_out | output | 1 | Bit-clock pin, driven value |
| bclk_oe | output | 1 | Bit-clock pin output enable |
| wsel_in | input | 1 | Word-select pin, received value |
| wsel_out | output | 1 | Word-select pin, driven value |
| wsel_oe | output | 1 | Word-select pin output enable |
| bit_en | output | 1 | One-cycle strobe per bit period |
| frame_start | output | 1 | One-cycle strobe per frame |

## Verification
The properties assume that reset is high at the first clock edge. They also assume that the slave-mode pins hold each level for at least three oversampling cycles, so that the synchronizers never miss an edge. The stimulus holds reset for two edges before every run. It changes `bclk_in` and `wsel_in` only at falling clock edges and leaves several cycles between changes.

The divider fields and `master_en` are changed freely in the middle of a frame. The shadowing and restart rules cover that case, and the properties only relate pin levels to the strobes.

// File: rtl/afg_pkg.sv
package afg_pkg;
  // Strobes delivered to the downstream shifter.
  typedef struct packed {
    logic bit_en;
    logic frame_start;
  } afg_strobe_t;
endpackage

// File: rtl/afg_bit_div.sv
// Divides the oversampling clock into bit periods of (ratio + 1) cycles.
module afg_bit_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] ratio,
  output logic          bit_first,
  output logic          bit_last,
  output logic          level
);
  localparam int HW = DW + 1;

  logic [DW-1:0] cnt;
  logic [HW-1:0] half;

  assign half      = HW'(({1'b0, ratio} + HW'(1)) >> 1);
  assign bit_first = run && (cnt == '0);
  assign bit_last  = run && (cnt == ratio);
  assign level     = run && ({1'b0, cnt} < half);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (bit_last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/afg_frame_div.sv
// Counts bit periods into frames of (len + 1) bits; word select low first.
module afg_frame_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [DW-1:0] len,
  output logic          pos_first,
  output logic          pos_last,
  output logic          level
);
  localparam int HW = DW + 1;

  logic [DW-1:0] pos;
  logic [HW-1:0] bits;
  logic [HW-1:0] low_bits;

  assign bits      = {1'b0, len} + HW'(1);
  assign low_bits  = bits - (bits >> 1);
  assign pos_first = run && (pos == '0);
  assign pos_last  = run && (pos == len);
  assign level     = run && ({1'b0, pos} >= low_bits);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos <= '0;
    end else if (step) begin
      if (pos_last) pos <= '0;
      else          pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/afg_edge_sync.sv
// Two-flop synchronizer followed by an edge detector; FALLING picks the edge.
module afg_edge_sync #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = s3 && !s2;
    end else begin : g_rise
      assign pulse = s2 && !s3;
    end
  endgenerate
endmodule

// File: rtl/aud_frame_gen.sv
module aud_frame_gen
  import afg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master_en,
  input  logic [DW-1:0] bclk_ratio,
  input  logic [DW-1:0] frame_len,
  input  logic          bclk_in,
  output logic          bclk_out,
  output logic          bclk_oe,
  input  logic          wsel_in,
  output logic          wsel_out,
  output logic          wsel_oe,
  output logic          bit_en,
  output logic          frame_start
);
  logic          running;
  logic [DW-1:0] act_ratio;
  logic [DW-1:0] act_len;
  logic          b_first, b_last, b_level;
  logic          f_first, f_last, f_level;
  logic          load;
  logic          s_bit, s_frame;
  afg_strobe_t   m_strb, s_strb, strb;

  // Shadow the divider fields at frame boundaries, or before the first frame.
  assign load = !running || (b_last && f_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      act_ratio <= '0;
      act_len   <= '0;
    end else begin
      running <= master_en;
      if (load) begin
        act_ratio <= bclk_ratio;
        act_len   <= frame_len;
      end
    end
  end

  afg_bit_div #(.DW(DW)) u_bit (
    .clk(clk), .rst(rst), .run(running), .ratio(act_ratio),
    .bit_first(b_first), .bit_last(b_last), .level(b_level)
  );

  afg_frame_div #(.DW(DW)) u_frame (
    .clk(clk), .rst(rst), .run(running), .step(b_last), .len(act_len),
    .pos_first(f_first), .pos_last(f_last), .level(f_level)
  );

  afg_edge_sync #(.FALLING(1'b0)) u_bsync (
    .clk(clk), .rst(rst), .pin(bclk_in), .pulse(s_bit)
  );

  afg_edge_sync #(.FALLING(1'b1)) u_wsync (
    .clk(clk), .rst(rst), .pin(wsel_in), .pulse(s_frame)
  );

  assign m_strb.bit_en      = b_first;
  assign m_strb.frame_start = b_first && f_first;
  assign s_strb.bit_en      = s_bit;
  assign s_strb.frame_start = s_frame;
  assign strb               = master_en ? m_strb : s_strb;

  assign bit_en      = strb.bit_en;
  assign frame_start = strb.frame_start;
  assign bclk_oe     = running;
  assign wsel_oe     = running;
  assign bclk_out    = b_level;
  assign wsel_out    = f_level;
endmodule

// File: rtl/afg_chk.sv
module afg_chk (
  input logic clk,
  input logic rst,
  input logic master_en,
  input logic bclk_out,
  input logic bclk_oe,
  input logic wsel_out,
  input logic wsel_oe,
  input logic bit_en,
  input logic frame_start
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bclk_oe && !wsel_oe && !bit_en && !frame_start));

  // R3
  bclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (bclk_oe && $rose(bclk_out)) |-> bit_en);

  // R4
  frame_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && frame_start) |-> bit_en);

  // R5
  ws_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (wsel_oe && $fell(wsel_out)) |-> frame_start);

  // R6
  driven_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && frame_start) |-> (bclk_oe && wsel_oe));

  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (!bclk_oe && !wsel_oe));
endmodule

bind aud_frame_gen afg_chk u_chk (
  .clk(clk), .rst(rst), .master_en(master_en),
  .bclk_out(bclk_out), .bclk_oe(bclk_oe),
  .wsel_out(wsel_out), .wsel_oe(wsel_oe),
  .bit_en(bit_en), .frame_start(frame_start)
);

// File: tb/sim_aud_frame_gen.sv
module sim_aud_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VEC_N [NVEC] = '{3, 5, 0, 1, 2, 4, 0, 255};
  localparam int VEC_W [NVEC] = '{63, 63, 7, 4, 0, 2, 0, 1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_en = 1'b1;
  logic [7:0] bclk_ratio = '0;
  logic [7:0] frame_len = '0;
  logic       bclk_in = 1'b0;
  logic       wsel_in = 1'b1;
  logic       bclk_out, bclk_oe, wsel_out, wsel_oe, bit_en, frame_start;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_frame_gen #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .master_en(master_en),
    .bclk_ratio(bclk_ratio), .frame_len(frame_len),
    .bclk_in(bclk_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .wsel_in(wsel_in), .wsel_out(wsel_out), .wsel_oe(wsel_oe),
    .bit_en(bit_en), .frame_start(frame_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset, run one master frame plus the next frame's first cycle, compare cycle by cycle.
  task automatic run_vec(input int n, input int w);
    int total, lowb, e_be, e_bc, e_ws, e_fs, e_oe;
    master_en = 1'b1;
    bclk_ratio = 8'(n);
    frame_len = 8'(w);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 quiet in reset", int'({bclk_oe, wsel_oe, bclk_out, wsel_out, bit_en, frame_start}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 first frame after reset", int'({frame_start, bclk_oe, wsel_oe}), 7);
    total = (n + 1) * (w + 1);
    lowb = (w + 1) - (w + 1) / 2;
    e_be = 0; e_bc = 0; e_ws = 0; e_fs = 0; e_oe = 0;
    for (int i = 0; i <= total; i++) begin
      int j, p, k;
      j = i % total;
      p = j % (n + 1);
      k = j / (n + 1);
      if (int'(bit_en) != int'(p == 0)) e_be++;
      if (int'(bclk_out) != int'(p < (n + 1) / 2)) e_bc++;
      if (int'(wsel_out) != int'(k >= lowb)) e_ws++;
      if (int'(frame_start) != int'(j == 0)) e_fs++;
      if (!(bclk_oe && wsel_oe)) e_oe++;
      if (i < total) @(negedge clk);
    end
    chk($sformatf("R2 bit_en mismatches n=%0d w=%0d", n, w), e_be, 0);
    chk($sformatf("R3 bclk level mismatches n=%0d w=%0d", n, w), e_bc, 0);
    chk($sformatf("R5 wsel level mismatches n=%0d w=%0d", n, w), e_ws, 0);
    chk($sformatf("R4 frame_start mismatches n=%0d w=%0d", n, w), e_fs, 0);
    chk($sformatf("R6 enable drops n=%0d w=%0d", n, w), e_oe, 0);
  endtask

  initial begin
    // Table-driven master runs.
    for (int v = 0; v < NVEC; v++) run_vec(VEC_N[v], VEC_W[v]);

    // R7: change fields mid-frame; the current frame keeps N=1, W=3.
    begin
      int fs_bad, be_a, be_b;
      master_en = 1'b1; bclk_ratio = 8'd1; frame_len = 8'd3; rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      fs_bad = 0; be_a = 0; be_b = 0;
      for (int i = 0; i <= 16; i++) begin
        if (int'(frame_start) != int'(i == 0 || i == 8 || i == 16)) fs_bad++;
        if (i < 8 && bit_en) be_a++;
        if (i >= 8 && i < 16 && bit_en) be_b++;
        if (i == 2) begin
          bclk_ratio = 8'd3;
          frame_len = 8'd1;
        end
        if (i < 16) @(negedge clk);
      end
      chk("R7 frame boundaries after mid-frame change", fs_bad, 0);
      chk("R7 old frame keeps 4 bits", be_a, 4);
      chk("R7 new frame has 2 bits", be_b, 2);
    end

    // R8 / R9: slave mode.
    master_en = 1'b0; bclk_in = 1'b0; wsel_in = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 slave pins not driven", int'({bclk_oe, wsel_oe, bclk_out, wsel_out}), 0);
    chk("R9 no frame_start on wsel rise", int'(frame_start), 0);
    bclk_in = 1'b1;
    @(negedge clk);
    chk("R8 no bit_en after one edge", int'(bit_en), 0);
    @(negedge clk);
    chk("R8 bit_en two edges after bclk rise", int'(bit_en), 1);
    @(negedge clk);
    chk("R8 bit_en lasts one cycle", int'(bit_en), 0);
    bclk_in = 1'b0;
    begin
      int cnt_be;
      cnt_be = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (bit_en) cnt_be++;
      end
      chk("R8 no bit_en on bclk fall", cnt_be, 0);
    end
    wsel_in = 1'b0;
    @(negedge clk);
    chk("R9 no frame_start after one edge", int'(frame_start), 0);
    @(negedge clk);
    chk("R9 frame_start two edges after wsel fall", int'(frame_start), 1);
    @(negedge clk);
    chk("R9 frame_start lasts one cycle", int'(frame_start), 0);

    // R10: back to master, fresh frame, then leave again.
    bclk_ratio = 8'd1; frame_len = 8'd1;
    master_en = 1'b1;
    @(negedge clk);
    chk("R10 fresh frame on return to master", int'({frame_start, bit_en, bclk_oe, wsel_oe, wsel_out}), 30);
    repeat (3) @(negedge clk);
    master_en = 1'b0;
    @(negedge clk);
    chk("R8 enables drop after leaving master", int'({bclk_oe, wsel_oe}), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule